// File: doc/BRIEF.md
# Twelve-Pin Parallel Port Expander

This block controls twelve bidirectional parallel pins behind a serial command port. It takes the 16-bit command word already executed by the serial front end, together with a one-cycle execute strobe. The low four bits of the word select the operation and the upper twelve bits carry the data. Three selects are decoded here:
- a write that loads the output latch;
- a direction-register write that decides which pins drive;
- a read that captures the pin values into a snapshot, which the serial port then shifts out.

The eight upper pins (4 to 11) are shared with analog output channels. Pin 4 pairs with channel 12 and pin 11 pairs with channel 5. For each of these pins an analog-enable flag comes in from the converter side. The block settles each pin's mode from the direction bit and that flag, and exports the result. A pin's mode is digital drive, analog drive or high impedance. The output latch has no reset, so data written before a reset appears again once the pin is set to drive.

Top module: `pexp_top`

## Requirements
- R1: On an execute strobe with select 4'b1101, command bits 15:4 load the output latch, with bit 4+i going to pin i. `pin_do_o[i]` shows latch bit i while pin i drives and reads 0 otherwise.
- R2: On an execute strobe with select 4'b1111, command bits 15:4 load the direction register, with bit 4+i going to pin i. From the next cycle, `pin_oe_o[i]` equals direction bit i.
- R3: On an execute strobe with select 4'b1110, the snapshot loads on that clock edge. It takes the pin input values, with a 0 for every pin whose direction bit is 1 or whose analog flag is set in that cycle. The snapshot then holds until the next such strobe.
- R4: The mode of a pin is decided in priority order. A direction bit of 1 gives digital drive, whatever the analog flag says. Otherwise a set analog flag gives analog drive, and otherwise the pin is in high impedance. Clearing the direction bit returns the pin to the mode its analog flag selects.
- R5: `ana_en_i[j]` belongs to pin 4+j, which is analog channel 12-j. Pins 0 to 3 never enter analog mode.
- R6: While reset is asserted, and after it is released, the direction register and the snapshot are zero. Every pin then has `pin_oe_o` low, and a pin with no analog flag reports high impedance.
- R7: The output latch keeps its contents through reset. After reset, setting a pin to drive shows the data written before the reset.
- R8: The direction register, the output latch and the snapshot change only on an execute strobe carrying their own select. Any other select, or no strobe, leaves all three unchanged.
- R9: `pin_mode_o[2i+1:2i]` reports the mode of pin i: 2'b00 is high impedance, 2'b01 is digital drive and 2'b10 is analog drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_i | input | 1 | One-cycle strobe: execute `cmd_i` |
| cmd_i | input | 16 | Executed command: [3:0] select, [15:4] data |
| ana_en_i | input | 8 | Analog-enable flags for pins 4 to 11 |
| pin_i | input | 12 | Values sensed on the pins |
| pin_oe_o | output | 12 | Per-pin output enable |
| pin_do_o | output | 12 | Per-pin output data (0 where not driving) |
| pin_mode_o | output | 24 | Per-pin 2-bit mode |
| snap_o | output | 12 | Readback snapshot for the serial port |

## Verification
The snapshot capture reads the analog flags and the pin values of the strobe cycle itself. A read strobe can therefore fall in the same cycle as a change of those flags. The stimulus table sets new analog flags and new pin values in the very cycle of each read strobe. The expected snapshot is judged against the flags of that cycle, not those of the cycle before. A direction write is also issued while an analog flag is held on that pin. The mode is checked to go from analog to digital and back to analog.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  typedef enum logic [1:0] {
    PM_HIZ = 2'b00,
    PM_DIG = 2'b01,
    PM_ANA = 2'b10
  } pin_mode_e;

  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_WRITE = 4'hD;
  localparam logic [SEL_W-1:0] SEL_READ  = 4'hE;
  localparam logic [SEL_W-1:0] SEL_DIR   = 4'hF;
endpackage

// File: rtl/pexp_dir_reg.sv
module pexp_dir_reg #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] dir_q
);
  logic [N-1:0] dir_d;

  always_comb begin
    dir_d = dir_q;
    if (wr_en) dir_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else        dir_q <= dir_d;
  end

  // R8: without a write the direction bits hold
  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dir_q));
endmodule

// File: rtl/pexp_out_latch.sv
module pexp_out_latch #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] lat_q
);
  logic [N-1:0] lat_d;

  always_comb begin
    lat_d = lat_q;
    if (wr_en) lat_d = wr_data;
  end

  // no reset: contents survive a reset (R7)
  always_ff @(posedge clk) begin
    lat_q <= lat_d;
  end
endmodule

// File: rtl/pexp_pin_mux.sv
module pexp_pin_mux
  import pexp_pkg::*;
#(
  parameter int N      = 12,
  parameter int ANA_LO = 4,
  localparam int N_ANA = N - ANA_LO
) (
  input  logic [N-1:0]     dir,
  input  logic [N-1:0]     lat,
  input  logic [N_ANA-1:0] ana_en,
  input  logic [N-1:0]     pin_in,
  output logic [N-1:0]     oe,
  output logic [N-1:0]     dout,
  output logic [2*N-1:0]   mode,
  output logic [N-1:0]     rd_val
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic ana;
    if (i >= ANA_LO) begin : g_shared
      assign ana = ana_en[i-ANA_LO];
    end else begin : g_digital
      assign ana = 1'b0;
    end

    pin_mode_e m;
    always_comb begin
      if (dir[i])   m = PM_DIG;
      else if (ana) m = PM_ANA;
      else          m = PM_HIZ;
    end

    assign mode[2*i +: 2] = m;
    assign oe[i]          = (m == PM_DIG);
    assign dout[i]        = (m == PM_DIG) ? lat[i] : 1'b0;
    assign rd_val[i]      = (m == PM_HIZ) ? pin_in[i] : 1'b0;
  end
endmodule

// File: rtl/pexp_snap.sv
module pexp_snap #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [N-1:0] rd_val,
  output logic [N-1:0] snap_q
);
  logic [N-1:0] snap_d;

  always_comb begin
    snap_d = snap_q;
    if (cap_en) snap_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  // R8: snapshot holds between read strobes
  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(snap_q));
endmodule

// File: rtl/pexp_top.sv
module pexp_top
  import pexp_pkg::*;
#(
  parameter int N      = 12,
  parameter int ANA_LO = 4,
  parameter int CMD_W  = 16,
  localparam int N_ANA = N - ANA_LO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [N_ANA-1:0] ana_en_i,
  input  logic [N-1:0]     pin_i,
  output logic [N-1:0]     pin_oe_o,
  output logic [N-1:0]     pin_do_o,
  output logic [2*N-1:0]   pin_mode_o,
  output logic [N-1:0]     snap_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  logic rst_sync_n;
  assign rst_sync_n = rst_pipe[1];

  logic [SEL_W-1:0] sel;
  logic [N-1:0]     cmd_data;
  assign sel      = cmd_i[SEL_W-1:0];
  assign cmd_data = cmd_i[SEL_W +: N];

  logic wr_dir, wr_lat, cap_snap;
  assign wr_dir   = exec_i && (sel == SEL_DIR);
  assign wr_lat   = exec_i && (sel == SEL_WRITE);
  assign cap_snap = exec_i && (sel == SEL_READ);

  logic [N-1:0] dir_q, lat_q, rd_val;

  pexp_dir_reg #(.N(N)) u_dir (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_dir), .wr_data(cmd_data), .dir_q(dir_q));

  pexp_out_latch #(.N(N)) u_lat (
    .clk(clk), .wr_en(wr_lat), .wr_data(cmd_data), .lat_q(lat_q));

  pexp_pin_mux #(.N(N), .ANA_LO(ANA_LO)) u_mux (
    .dir(dir_q), .lat(lat_q), .ana_en(ana_en_i), .pin_in(pin_i),
    .oe(pin_oe_o), .dout(pin_do_o), .mode(pin_mode_o), .rd_val(rd_val));

  pexp_snap #(.N(N)) u_snap (
    .clk(clk), .rst_n(rst_sync_n), .cap_en(cap_snap), .rd_val(rd_val), .snap_q(snap_o));

  // R2: a direction write shows on the enables one cycle later
  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_dir |=> pin_oe_o == $past(cmd_data));

  // R1: after a latch write, every driving pin carries the written bit
  assert_lat_drive_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_lat |=> ((pin_do_o ^ $past(cmd_data)) & pin_oe_o) == '0);

  // R3: the snapshot is zero wherever the pin drove or was analog at capture
  assert_snap_mask_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_snap |=> (snap_o & $past(pin_oe_o | {ana_en_i, {ANA_LO{1'b0}}})) == '0);
endmodule

// File: tb/tb_pexp_top.sv
module tb_pexp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_i;
  logic [15:0] cmd_i;
  logic [7:0]  ana_en_i;
  logic [11:0] pin_i;
  logic [11:0] pin_oe_o, pin_do_o, snap_o;
  logic [23:0] pin_mode_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pexp_top dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .cmd_i(cmd_i), .ana_en_i(ana_en_i),
    .pin_i(pin_i), .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o), .pin_mode_o(pin_mode_o),
    .snap_o(snap_o));

  // {cmd, ana_en, pins, expected oe, expected do, expected snapshot}
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {16'hA5CD, 8'h00, 12'h000, 12'h000, 12'h000, 12'h000}, // R1 latch write, nothing drives
    {16'h0FFF, 8'h00, 12'h000, 12'h0FF, 12'h05C, 12'h000}, // R2 direction write
    {16'h000E, 8'h0F, 12'hFFF, 12'h0FF, 12'h05C, 12'hF00}, // R3 analog flags change at capture
    {16'h3C3D, 8'h00, 12'h000, 12'h0FF, 12'h0C3, 12'hF00}, // R1 rewrite latch
    {16'hF00F, 8'h00, 12'h000, 12'hF00, 12'h300, 12'hF00}, // R2 swap drivers
    {16'h000E, 8'hF0, 12'hA5A, 12'hF00, 12'h300, 12'h05A}, // R3 second capture
    {16'h1234, 8'h00, 12'hFFF, 12'hF00, 12'h300, 12'h05A}, // R8 analog channel select ignored
    {16'hFFF0, 8'h00, 12'hFFF, 12'hF00, 12'h300, 12'h05A}  // R8 special select ignored
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [15:0] c, input logic [7:0] a, input logic [11:0] p);
    @(negedge clk);
    cmd_i = c; ana_en_i = a; pin_i = p; exec_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; exec_i = 1'b0; cmd_i = '0; ana_en_i = '0; pin_i = '0;
    repeat (3) @(negedge clk);
    chk("R6 oe in reset", {12'h0, pin_oe_o}, 24'h0);
    chk("R6 snap in reset", {12'h0, snap_o}, 24'h0);
    chk("R9 mode HIZ in reset", pin_mode_o, 24'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 oe after release", {12'h0, pin_oe_o}, 24'h0);

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i][71:56], VEC[i][55:48], VEC[i][47:36]);
      chk($sformatf("R2 oe vec%0d", i), {12'h0, pin_oe_o}, {12'h0, VEC[i][35:24]});
      chk($sformatf("R1 do vec%0d", i), {12'h0, pin_do_o}, {12'h0, VEC[i][23:12]});
      chk($sformatf("R3 snap vec%0d", i), {12'h0, snap_o}, {12'h0, VEC[i][11:0]});
    end

    // R8: no strobe, command with write select present: nothing changes
    @(negedge clk);
    cmd_i = 16'hFFFD; exec_i = 1'b0;
    @(negedge clk);
    chk("R8 no strobe do", {12'h0, pin_do_o}, 24'h000300);

    // R7: latch survives reset
    rst_n = 1'b0;
    @(negedge clk);
    chk("R6 oe cleared by reset", {12'h0, pin_oe_o}, 24'h0);
    chk("R6 snap cleared by reset", {12'h0, snap_o}, 24'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_cmd(16'hFFFF, 8'h00, 12'h000);
    chk("R7 latch kept", {12'h0, pin_do_o}, 24'h0003C3);

    // R4 priority on pin 5 (ana_en_i[1])
    run_cmd(16'h000F, 8'h02, 12'h000);
    chk("R4 analog when dir 0", {22'h0, pin_mode_o[11:10]}, 24'h2);
    run_cmd(16'h020F, 8'h02, 12'h000);
    chk("R4 dir wins over analog", {22'h0, pin_mode_o[11:10]}, 24'h1);
    chk("R4 oe pin5", {12'h0, pin_oe_o}, 24'h000020);
    run_cmd(16'h000F, 8'h02, 12'h000);
    chk("R4 analog restored", {22'h0, pin_mode_o[11:10]}, 24'h2);

    // R5 mapping and R9 encoding
    @(negedge clk);
    ana_en_i = 8'h80;
    #1 chk("R5 flag7 -> pin11", pin_mode_o, 24'h800000);
    ana_en_i = 8'h01;
    #1 chk("R5 flag0 -> pin4", pin_mode_o, 24'h000200);
    ana_en_i = 8'hFF;
    #1 chk("R5 pins0-3 never analog", {16'h0, pin_mode_o[7:0]}, 24'h0);
    chk("R9 all upper pins analog", {8'h0, pin_mode_o[23:8]}, 24'h00AAAA);

    // R3 capture with pins changing in the strobe cycle, analog on pin 4 only
    run_cmd(16'h000E, 8'h01, 12'hFFF);
    chk("R3 same-cycle capture", {12'h0, snap_o}, 24'h000FEF);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule